// File: doc/BRIEF.md
# Indirect SFR Window to a 9-bit Peripheral Register Port

This bridge lets an 8-bit microcontroller reach a multi-channel serial-bus controller through its external special-function-register bus. The controller exposes a 9-bit register address and an 8-bit data port. Its address space is too large to map directly into the SFR space, so the bridge offers an indirect window of four consecutive SFRs. These are a low address byte, a high address and control byte, a write-data byte and a read-data byte. The CPU and the controller run on one clock, so the bridge has no synchronisers.

Firmware writes the address first and then starts an access. If it sets the write-arm bit, each write to the write-data SFR issues a one-cycle write strobe to the controller. If it writes the read-go bit, the bridge issues a one-cycle read strobe, captures the returned byte and raises a ready flag. Firmware polls that flag and then fetches the byte. A 32-bit word held by the controller takes four such byte accesses, selected by the two low address bits.

Top module: `sfr_bridge`

## Requirements
- R1: The 7-bit SFR address selects four registers: BASE_ADDR+0 (default 0x40) is the low address byte, +1 is the high/control byte, +2 is write data and +3 is read data. `sfrRdData` shows the selected register combinationally. Any other address reads 0, and writes to it change nothing.
- R2: `periAddr` equals {control bit 0, low address byte}. Within it, bits [8:5] are the channel (0..15), bit 4 selects transmit or receive, bits [3:2] are the register index and bits [1:0] are the byte lane. `periAddr` changes only in the cycle after a write to one of the two address SFRs.
- R3: The control byte uses bit 0 for address bit 8, bit 1 for write-arm, bit 2 for read-go and bit 7 for ready. Bit 2 is a command and always reads 0. Bits 6:3 read 0. Bit 7 is read-only, and writing it has no effect.
- R4: A write to the write-data SFR stores the byte. When write-arm is 1 at that moment, `periWrStrobe` is high for exactly the next cycle, with `periWrData` equal to the written byte and `periAddr` at the latched address. When write-arm is 0, no strobe occurs.
- R5: Writing the control byte with bit 2 set drives `periRdStrobe` high for exactly the next cycle. The `periRdData` value seen in that cycle is captured into the read-data SFR, and ready reads 1 from the cycle after the strobe.
- R6: Ready falls after a CPU read of the read-data SFR, after a read-go command, or after an armed write-data write.
- R7: If a read strobe completes in the same cycle that the CPU reads the read-data SFR, the CPU gets the old byte and ready ends up 1.
- R8: While reset is asserted, every register reads 0 and both strobes are low.
- R9: Four byte-lane accesses (lanes 0..3) to one register index read or write a full 32-bit word of the controller byte by byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared CPU/peripheral clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sfrAddr | input | 7 | External SFR address (top bit of the 8-bit SFR address removed) |
| sfrWrEn | input | 1 | SFR write enable |
| sfrRdEn | input | 1 | SFR read enable |
| sfrWrData | input | 8 | SFR write data |
| sfrRdData | output | 8 | SFR read data, combinational |
| periAddr | output | 9 | Peripheral register address |
| periWrData | output | 8 | Peripheral write data |
| periWrStrobe | output | 1 | One-cycle peripheral write strobe |
| periRdStrobe | output | 1 | One-cycle peripheral read strobe |
| periRdData | input | 8 | Peripheral read data, sampled during the read strobe |

## Verification
Two events can fall in the same cycle. The completion of a read strobe sets ready, and a CPU read of the read-data SFR clears it. The bench provokes this by reading the read-data SFR in the cycle directly after a read-go write. A reference model compares every output on every clock, and a directed check then requires ready to read 1 and the newly captured byte to be present. The bench also places an armed write right after a completed read, so that the clear caused by the armed write is judged against the set caused by the read.

// File: rtl/sfr_bridge_pkg.sv
package sfr_bridge_pkg;

  // register selected within the four-SFR window
  typedef enum logic [1:0] {
    SEL_LO = 2'd0,
    SEL_HI = 2'd1,
    SEL_WD = 2'd2,
    SEL_RD = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    ldLo;     // load low address byte
    logic    ldHi;     // load high address bits and write-arm
    logic    ldWd;     // load write-data byte
    logic    capture;  // capture peripheral read byte
    logic    rdHit;    // SFR address falls in the window
    regSel_e rdSel;    // which register drives the read mux
  } dpCtl_t;

endpackage

// File: rtl/sfr_bridge_ctrl.sv
module sfr_bridge_ctrl
  import sfr_bridge_pkg::*;
#(
  parameter int                    SFR_ADDR_W = 7,
  parameter logic [SFR_ADDR_W-1:0] BASE_ADDR  = 7'h40
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [SFR_ADDR_W-1:0] sfrAddr,
  input  logic                  sfrWrEn,
  input  logic                  sfrRdEn,
  input  logic                  goBit,
  input  logic                  wrArm,
  output dpCtl_t                dpCtl,
  output logic                  periWrStrobe,
  output logic                  periRdStrobe,
  output logic                  ready
);

  localparam logic [SFR_ADDR_W-1:0] WINDOW = SFR_ADDR_W'(4);

  logic [SFR_ADDR_W-1:0] offs;
  logic                  hit;
  regSel_e               sel;
  logic                  wrLo, wrHi, wrWd, rdRd;
  logic                  goRd, goWr;
  logic                  wrStbQ, rdStbQ, readyQ;

  // window decode
  always_comb begin
    offs = sfrAddr - BASE_ADDR;
    hit  = (offs < WINDOW);
    sel  = regSel_e'(offs[1:0]);
  end

  always_comb begin
    wrLo = sfrWrEn && hit && (sel == SEL_LO);
    wrHi = sfrWrEn && hit && (sel == SEL_HI);
    wrWd = sfrWrEn && hit && (sel == SEL_WD);
    rdRd = sfrRdEn && hit && (sel == SEL_RD);
    goRd = wrHi && goBit;
    goWr = wrWd && wrArm;
  end

  // strobe generation, one cycle after the triggering SFR write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrStbQ <= 1'b0;
      rdStbQ <= 1'b0;
    end else begin
      wrStbQ <= goWr;
      rdStbQ <= goRd;
    end
  end

  // ready flag: set on capture (wins), cleared by consumption or new command
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyQ <= 1'b0;
    end else if (rdStbQ) begin
      readyQ <= 1'b1;
    end else if (rdRd || goRd || goWr) begin
      readyQ <= 1'b0;
    end
  end

  always_comb begin
    dpCtl.ldLo    = wrLo;
    dpCtl.ldHi    = wrHi;
    dpCtl.ldWd    = wrWd;
    dpCtl.capture = rdStbQ;
    dpCtl.rdHit   = hit;
    dpCtl.rdSel   = sel;
  end

  assign periWrStrobe = wrStbQ;
  assign periRdStrobe = rdStbQ;
  assign ready        = readyQ;

  // R5
  rd_strobe_sets_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    periRdStrobe |=> ready)
    else $error("ready not set after read strobe");

  // R6
  ready_drop_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ready) |-> $past(rdRd || goRd || goWr))
    else $error("ready fell without a clearing cause");

  // R4
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({periWrStrobe, periRdStrobe}))
    else $error("read and write strobes together");

  // R3
  ready_ro_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrHi && !goBit && !periRdStrobe && !ready) |=> !ready)
    else $error("control write set ready");

endmodule

// File: rtl/sfr_bridge_dp.sv
module sfr_bridge_dp
  import sfr_bridge_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HI_W   = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DATA_W-1:0]    sfrWrData,
  input  dpCtl_t               dpCtl,
  input  logic                 ready,
  input  logic [DATA_W-1:0]    periRdData,
  output logic                 wrArm,
  output logic [DATA_W-1:0]    sfrRdData,
  output logic [HI_W+DATA_W-1:0] periAddr,
  output logic [DATA_W-1:0]    periWrData
);

  localparam int ARM_POS = HI_W;
  localparam int RDY_POS = DATA_W - 1;

  logic [DATA_W-1:0] addrLoQ;
  logic [HI_W-1:0]   addrHiQ;
  logic              wrArmQ;
  logic [DATA_W-1:0] wrDataQ;
  logic [DATA_W-1:0] rdDataQ;
  logic [DATA_W-1:0] hiView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLoQ <= '0;
      addrHiQ <= '0;
      wrArmQ  <= 1'b0;
      wrDataQ <= '0;
      rdDataQ <= '0;
    end else begin
      if (dpCtl.ldLo) addrLoQ <= sfrWrData;
      if (dpCtl.ldHi) begin
        addrHiQ <= sfrWrData[HI_W-1:0];
        wrArmQ  <= sfrWrData[ARM_POS];
      end
      if (dpCtl.ldWd)    wrDataQ <= sfrWrData;
      if (dpCtl.capture) rdDataQ <= periRdData;
    end
  end

  // control byte as seen by the CPU
  always_comb begin
    hiView            = '0;
    hiView[HI_W-1:0]  = addrHiQ;
    hiView[ARM_POS]   = wrArmQ;
    hiView[RDY_POS]   = ready;
  end

  always_comb begin
    sfrRdData = '0;
    if (dpCtl.rdHit) begin
      unique case (dpCtl.rdSel)
        SEL_LO: sfrRdData = addrLoQ;
        SEL_HI: sfrRdData = hiView;
        SEL_WD: sfrRdData = wrDataQ;
        SEL_RD: sfrRdData = rdDataQ;
        default: sfrRdData = '0;
      endcase
    end
  end

  assign wrArm      = wrArmQ;
  assign periAddr   = {addrHiQ, addrLoQ};
  assign periWrData = wrDataQ;

  // R4
  wd_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.ldWd |=> (periWrData == $past(sfrWrData)))
    else $error("write data not latched");

  // R5
  rd_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.capture |=> (rdDataQ == $past(periRdData)))
    else $error("read data not captured");

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(dpCtl.ldLo || dpCtl.ldHi) |=> $stable(periAddr))
    else $error("peripheral address moved without an address write");

endmodule

// File: rtl/sfr_bridge.sv
module sfr_bridge
  import sfr_bridge_pkg::*;
#(
  parameter int                    SFR_ADDR_W  = 7,
  parameter int                    DATA_W      = 8,
  parameter int                    PERI_ADDR_W = 9,
  parameter logic [SFR_ADDR_W-1:0] BASE_ADDR   = 7'h40
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [SFR_ADDR_W-1:0]  sfrAddr,
  input  logic                   sfrWrEn,
  input  logic                   sfrRdEn,
  input  logic [DATA_W-1:0]      sfrWrData,
  output logic [DATA_W-1:0]      sfrRdData,
  output logic [PERI_ADDR_W-1:0] periAddr,
  output logic [DATA_W-1:0]      periWrData,
  output logic                   periWrStrobe,
  output logic                   periRdStrobe,
  input  logic [DATA_W-1:0]      periRdData
);

  localparam int HI_W   = PERI_ADDR_W - DATA_W;
  localparam int GO_POS = HI_W + 1;

  dpCtl_t dpCtl;
  logic   wrArm;
  logic   ready;

  sfr_bridge_ctrl #(
    .SFR_ADDR_W (SFR_ADDR_W),
    .BASE_ADDR  (BASE_ADDR)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .sfrAddr      (sfrAddr),
    .sfrWrEn      (sfrWrEn),
    .sfrRdEn      (sfrRdEn),
    .goBit        (sfrWrData[GO_POS]),
    .wrArm        (wrArm),
    .dpCtl        (dpCtl),
    .periWrStrobe (periWrStrobe),
    .periRdStrobe (periRdStrobe),
    .ready        (ready)
  );

  sfr_bridge_dp #(
    .DATA_W (DATA_W),
    .HI_W   (HI_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sfrWrData  (sfrWrData),
    .dpCtl      (dpCtl),
    .ready      (ready),
    .periRdData (periRdData),
    .wrArm      (wrArm),
    .sfrRdData  (sfrRdData),
    .periAddr   (periAddr),
    .periWrData (periWrData)
  );

endmodule

// File: tb/sfr_bridge_tb.sv
`timescale 1ns/1ps
module sfr_bridge_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [6:0] sfrAddr = '0;
  logic       sfrWrEn = 1'b0;
  logic       sfrRdEn = 1'b0;
  logic [7:0] sfrWrData = '0;
  logic [7:0] sfrRdData;
  logic [8:0] periAddr;
  logic [7:0] periWrData;
  logic       periWrStrobe;
  logic       periRdStrobe;
  logic [7:0] periRdData;

  int nCmp = 0;
  int nBad = 0;
  bit cmpEn = 1'b0;

  always #4 clk = ~clk;

  sfr_bridge u_dut (
    .clk(clk), .rstN(rstN), .sfrAddr(sfrAddr), .sfrWrEn(sfrWrEn),
    .sfrRdEn(sfrRdEn), .sfrWrData(sfrWrData), .sfrRdData(sfrRdData),
    .periAddr(periAddr), .periWrData(periWrData), .periWrStrobe(periWrStrobe),
    .periRdStrobe(periRdStrobe), .periRdData(periRdData)
  );

  // peripheral register file
  logic [7:0] perMem [0:511];
  initial for (int i = 0; i < 512; i++) perMem[i] = 8'((i * 37 + 5) ^ (i >> 3));
  assign periRdData = perMem[periAddr];
  always @(posedge clk) if (periWrStrobe) perMem[periAddr] <= periWrData;

  // behavioural reference model
  logic [7:0] mLo, mWd, mRd;
  logic       mMsb, mArm, mReady, mWrStb, mRdStb;

  always @(posedge clk) begin
    if (!rstN) begin
      mLo <= 0; mWd <= 0; mRd <= 0; mMsb <= 0; mArm <= 0;
      mReady <= 0; mWrStb <= 0; mRdStb <= 0;
    end else begin
      automatic bit wr = sfrWrEn;
      automatic bit goR = wr && sfrAddr == 7'h41 && sfrWrData[2];
      automatic bit goW = wr && sfrAddr == 7'h42 && mArm;
      automatic bit rdR = sfrRdEn && sfrAddr == 7'h43;
      if (wr && sfrAddr == 7'h40) mLo <= sfrWrData;
      if (wr && sfrAddr == 7'h41) begin mMsb <= sfrWrData[0]; mArm <= sfrWrData[1]; end
      if (wr && sfrAddr == 7'h42) mWd <= sfrWrData;
      if (mRdStb) mRd <= periRdData;
      mWrStb <= goW;
      mRdStb <= goR;
      if (mRdStb) mReady <= 1'b1;
      else if (rdR || goR || goW) mReady <= 1'b0;
    end
  end

  function automatic logic [7:0] expRd(input logic [6:0] a);
    case (a)
      7'h40: return mLo;
      7'h41: return {mReady, 5'b0, mArm, mMsb};
      7'h42: return mWd;
      7'h43: return mRd;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s at %0t: actual 0x%0h expected 0x%0h", req, $time, act, exp);
    end
  endtask

  // every-clock comparison, away from the active edge
  always @(negedge clk) if (cmpEn) begin
    check("R1 sfrRdData", sfrRdData, expRd(sfrAddr));
    check("R2 periAddr", periAddr, {mMsb, mLo});
    check("R4 periWrStrobe", periWrStrobe, mWrStb);
    check("R4 periWrData", periWrData, mWd);
    check("R5 periRdStrobe", periRdStrobe, mRdStb);
  end

  task automatic sfrWrite(input logic [6:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    sfrAddr = a; sfrWrData = d; sfrWrEn = 1'b1;
    @(posedge clk); #1;
    sfrWrEn = 1'b0;
  endtask

  task automatic sfrRead(input logic [6:0] a, output logic [7:0] d);
    @(posedge clk); #1;
    sfrAddr = a; sfrRdEn = 1'b1;
    #2 d = sfrRdData;
    @(posedge clk); #1;
    sfrRdEn = 1'b0;
  endtask

  task automatic setAddr(input logic [8:0] a, input bit arm);
    sfrWrite(7'h40, a[7:0]);
    sfrWrite(7'h41, {6'b0, arm, a[8]});
  endtask

  task automatic peripheralRead(input logic [8:0] a, output logic [7:0] d);
    logic [7:0] ctl;
    sfrWrite(7'h40, a[7:0]);
    sfrWrite(7'h41, {5'b0, 1'b1, 1'b0, a[8]});
    do sfrRead(7'h41, ctl); while (!ctl[7]);
    sfrRead(7'h43, d);
  endtask

  initial begin
    #(8 * 200000);
    nBad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] ctl;
    logic [31:0] word;
    // R8: reset state
    repeat (2) @(posedge clk);
    for (int a = 'h40; a < 'h44; a++) begin
      #1 sfrAddr = 7'(a);
      #1 check("R8 reset read", sfrRdData, 0);
    end
    check("R8 reset strobes", {periWrStrobe, periRdStrobe}, 0);
    @(posedge clk); #1 rstN = 1'b1;
    @(posedge clk); #1 cmpEn = 1'b1;

    // R1: window registers and out-of-window addresses
    sfrWrite(7'h40, 8'hA5);
    sfrRead(7'h40, v);  check("R1 addrLo readback", v, 8'hA5);
    sfrWrite(7'h44, 8'h3C);
    sfrWrite(7'h3F, 8'hFF);
    sfrRead(7'h44, v);  check("R1 outside reads 0", v, 0);
    sfrRead(7'h40, v);  check("R1 outside write ignored", v, 8'hA5);

    // R3: control byte layout, go bit reads 0, ready read-only
    sfrWrite(7'h41, 8'hFB);
    sfrRead(7'h41, v);  check("R3 control readback", v, 8'h03);
    sfrWrite(7'h41, 8'h80);
    sfrRead(7'h41, v);  check("R3 ready not writable", v, 8'h00);

    // R4: unarmed write stores byte but does not reach the peripheral
    setAddr(9'h0A4, 1'b0);
    sfrWrite(7'h42, 8'h5E);
    sfrRead(7'h42, v);  check("R4 write data readback", v, 8'h5E);
    check("R4 unarmed no write", perMem[9'h0A4], 8'((9'h0A4 * 37 + 5) ^ (9'h0A4 >> 3)));

    // R4: armed write
    setAddr(9'h1B2, 1'b1);
    sfrWrite(7'h42, 8'hC3);
    peripheralRead(9'h1B2, v);
    check("R4 armed write landed", v, 8'hC3);

    // R2 + R9: 32-bit word over four lanes, channel 5 transmit register 0
    for (int lane = 0; lane < 4; lane++) begin
      setAddr({4'd5, 1'b1, 2'd0, 2'(lane)}, 1'b1);
      sfrWrite(7'h42, 8'(8'h10 * (lane + 1) + lane));
    end
    word = '0;
    for (int lane = 0; lane < 4; lane++) begin
      peripheralRead({4'd5, 1'b1, 2'd0, 2'(lane)}, v);
      word[lane*8 +: 8] = v;
    end
    check("R9 word by lanes", word, 32'h43322110);

    // R5 + R6: read go, ready, then read-data access clears ready
    peripheralRead({4'd15, 1'b0, 2'd3, 2'd2}, v);
    check("R5 read byte", v, perMem[{4'd15, 1'b0, 2'd3, 2'd2}]);
    sfrRead(7'h41, ctl); check("R6 ready cleared by data read", ctl[7], 0);

    // R6: armed write clears ready
    sfrWrite(7'h40, 8'h11);
    sfrWrite(7'h41, 8'h06);
    sfrRead(7'h41, ctl); check("R6 ready before armed write", ctl[7], 1);
    sfrWrite(7'h42, 8'h77);
    sfrRead(7'h41, ctl); check("R6 ready cleared by armed write", ctl[7], 0);

    // R6: new read go clears ready until the strobe sets it again
    sfrWrite(7'h41, 8'h04);
    sfrRead(7'h41, ctl); check("R6 ready after go", ctl[7], 1);

    // R7: capture and CPU read of read-data in the same cycle
    sfrWrite(7'h40, 8'h22);
    sfrRead(7'h43, v);
    @(posedge clk); #1;
    sfrAddr = 7'h41; sfrWrData = 8'h04; sfrWrEn = 1'b1;
    @(posedge clk); #1;
    sfrWrEn = 1'b0; sfrAddr = 7'h43; sfrRdEn = 1'b1;
    #2 check("R7 old byte returned", sfrRdData, v);
    @(posedge clk); #1 sfrRdEn = 1'b0;
    sfrRead(7'h41, ctl); check("R7 ready wins", ctl[7], 1);
    sfrRead(7'h43, v);  check("R7 new byte", v, perMem[9'h022]);

    repeat (3) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule